// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(2^12). The larger field is built as a quadratic extension over GF(2^6). Each operand splits into an upper 6-bit half (bits 11:6) and a lower 6-bit half (bits 5:0). Three GF(64) products are formed and then combined into the two halves of the result. It is meant for Reed-Solomon arithmetic, where syndromes and locator terms need many multiplications on a stream of symbols.

A second mode, selected per operation, computes a power step. A zero input yields one. Any other input yields that input times the fixed element 0xE01. Feeding each result back in produces a chain of successive powers.

Both modes share one two-stage pipeline with a valid strobe. A new operation can be accepted on every clock.

Top module: `gf4k_tower_mul`

## Requirements
- R1: The GF(64) base multiply reduces modulo x^6 + x + 1. The upper result half equals (ah^al)*(bh^bl) ^ al*bl, computed in GF(64), where ah/al are bits 11:6 / 5:0 of `op_a`, and bh/bl are the same halves of `op_b`.
- R2: The lower result half (bits 5:0) equals (ah*bh)*0x21 ^ al*bl in GF(64). The 12-bit result is the upper half shifted left by six, XOR the lower half.
- R3: With `step_mode` = 0, a zero in either operand gives a `product` of 0.
- R4: With `step_mode` = 0 and `op_a` = 0x001, `product` equals `op_b`.
- R5: Swapping `op_a` and `op_b` does not change `product`.
- R6: With `step_mode` = 1 and `op_a` = 0, `product` is 0x001, whatever `op_b` is.
- R7: With `step_mode` = 1 and `op_a` nonzero, `product` is `op_a` times 0xE01, and `op_b` is ignored.
- R8: An operation accepted with `in_valid` = 1 at a rising edge appears on `product` with `out_valid` = 1 after exactly two rising edges. A new operation may be accepted every cycle.
- R9: `product` keeps its value in any cycle whose matching input slot, two edges earlier, had `in_valid` = 0.
- R10: While `rst_n` is low, `out_valid` and `product` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| step_mode | input | 1 | 1: power step on op_a; 0: op_a times op_b |
| op_a | input | 12 | First operand, or step input |
| op_b | input | 12 | Second operand (unused in step mode) |
| out_valid | output | 1 | product holds a new result |
| product | output | 12 | Registered result |

## Verification
The assertions check four things on every cycle:
- the two-cycle valid latency,
- that the output holds when no operation is in flight,
- a zero operand giving zero, and the unit element returning the other operand,
- step mode mapping zero to one.

The exact arithmetic of the two halves needs the bench's scenarios. These are random operand pairs, swapped pairs, and step chains checked against an independently computed tower-field model. Back-to-back streaming and gaps in the valid pattern are also shown by the scenarios.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;
  // Width of the base field GF(2^6)
  localparam int unsigned HALF_W = 6;
  // Width of the extension field element
  localparam int unsigned FULL_W = 2 * HALF_W;
  // Reduction tail of x^6 + x + 1 (x^6 term dropped)
  localparam logic [HALF_W-1:0] BASE_POLY_TAIL = 6'h03;
  // Constant term of the quadratic extension
  localparam logic [HALF_W-1:0] EXT_CONST = 6'h21;
  // Multiplier used by the power step
  localparam logic [FULL_W-1:0] STEP_ELEM = 12'hE01;

  typedef struct packed {
    logic [HALF_W-1:0] mix;   // (ah^al)*(bh^bl)
    logic [HALF_W-1:0] lolo;  // al*bl
    logic [HALF_W-1:0] hihi;  // ah*bh
    logic              force_one;
  } gf4k_partial_t;
endpackage

// File: rtl/gf64_mult.sv
module gf64_mult #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] POLY_TAIL = 6'h03
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  // Shift-and-add: bsh[i] is b*x^i reduced, acc[i] the partial sum
  logic [W-1:0] bsh [0:W-1];
  logic [W-1:0] acc [0:W];

  assign bsh[0] = b_i;
  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign acc[i+1] = acc[i] ^ (a_i[i] ? bsh[i] : '0);
    if (i < W - 1) begin : g_shift
      assign bsh[i+1] = bsh[i][W-1] ? ({bsh[i][W-2:0], 1'b0} ^ POLY_TAIL)
                                    : {bsh[i][W-2:0], 1'b0};
    end
  end

  assign p_o = acc[W];
endmodule

// File: rtl/gf4k_stage1.sv
module gf4k_stage1
  import gf4k_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FULL_W-1:0] a_i,
  input  logic [FULL_W-1:0] b_i,
  input  logic              force_one_i,
  output gf4k_partial_t     part_o
);
  logic [HALF_W-1:0] ah, al, bh, bl;
  logic [HALF_W-1:0] m_mix, m_lolo, m_hihi;
  gf4k_partial_t     part_d, part_q;

  assign ah = a_i[FULL_W-1:HALF_W];
  assign al = a_i[HALF_W-1:0];
  assign bh = b_i[FULL_W-1:HALF_W];
  assign bl = b_i[HALF_W-1:0];

  gf64_mult #(.W(HALF_W), .POLY_TAIL(BASE_POLY_TAIL)) u_mix (
    .a_i(ah ^ al), .b_i(bh ^ bl), .p_o(m_mix));
  gf64_mult #(.W(HALF_W), .POLY_TAIL(BASE_POLY_TAIL)) u_lolo (
    .a_i(al), .b_i(bl), .p_o(m_lolo));
  gf64_mult #(.W(HALF_W), .POLY_TAIL(BASE_POLY_TAIL)) u_hihi (
    .a_i(ah), .b_i(bh), .p_o(m_hihi));

  always_comb begin
    part_d = part_q;
    if (en) begin
      part_d.mix       = m_mix;
      part_d.lolo      = m_lolo;
      part_d.hihi      = m_hihi;
      part_d.force_one = force_one_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) part_q <= '0;
    else        part_q <= part_d;
  end

  assign part_o = part_q;
endmodule

// File: rtl/gf4k_stage2.sv
module gf4k_stage2
  import gf4k_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  gf4k_partial_t     part_i,
  output logic [FULL_W-1:0] prod_o
);
  logic [HALF_W-1:0] hh_scaled;
  logic [HALF_W-1:0] res_hi, res_lo;
  logic [FULL_W-1:0] prod_d, prod_q;

  gf64_mult #(.W(HALF_W), .POLY_TAIL(BASE_POLY_TAIL)) u_scale (
    .a_i(part_i.hihi), .b_i(EXT_CONST), .p_o(hh_scaled));

  assign res_hi = part_i.mix ^ part_i.lolo;
  assign res_lo = hh_scaled ^ part_i.lolo;

  always_comb begin
    prod_d = prod_q;
    if (en) begin
      if (part_i.force_one) prod_d = FULL_W'(1);
      else                  prod_d = {res_hi, res_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/gf4k_tower_mul.sv
module gf4k_tower_mul
  import gf4k_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              step_mode,
  input  logic [FULL_W-1:0] op_a,
  input  logic [FULL_W-1:0] op_b,
  output logic              out_valid,
  output logic [FULL_W-1:0] product
);
  logic              vld1_q, vld2_q;
  logic [FULL_W-1:0] b_sel;
  logic              force_one;
  gf4k_partial_t     part;

  // Step mode replaces the second operand by the fixed element
  assign b_sel     = step_mode ? STEP_ELEM : op_b;
  assign force_one = step_mode && (op_a == '0);

  gf4k_stage1 u_s1 (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .a_i(op_a), .b_i(b_sel), .force_one_i(force_one), .part_o(part));

  gf4k_stage2 u_s2 (
    .clk(clk), .rst_n(rst_n), .en(vld1_q),
    .part_i(part), .prod_o(product));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
    end else begin
      vld1_q <= in_valid;
      vld2_q <= vld1_q;
    end
  end

  assign out_valid = vld2_q;
endmodule

// File: rtl/gf4k_tower_mul_chk.sv
module gf4k_tower_mul_chk
  import gf4k_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              step_mode,
  input logic [FULL_W-1:0] op_a,
  input logic [FULL_W-1:0] op_b,
  input logic              out_valid,
  input logic [FULL_W-1:0] product
);
  // Edges seen since reset release, saturating at 2
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && !$past(in_valid, 2)) |-> $stable(product)); // R9

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && $past(in_valid && !step_mode && (op_a == '0 || op_b == '0), 2))
      |-> (product == '0)); // R3

  AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && $past(in_valid && !step_mode && op_a == FULL_W'(1), 2))
      |-> (product == $past(op_b, 2))); // R4

  AST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && $past(in_valid && step_mode && op_a == '0, 2))
      |-> (product == FULL_W'(1))); // R6

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (out_valid == 1'b0); // R10
    end
  end
endmodule

bind gf4k_tower_mul gf4k_tower_mul_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_mode(step_mode),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product));

// File: tb/sim_gf4k_tower_mul.sv
`timescale 1ns/1ps
module sim_gf4k_tower_mul;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        step_mode;
  logic [11:0] op_a;
  logic [11:0] op_b;
  logic        out_valid;
  logic [11:0] product;

  int checks = 0;
  int errors = 0;

  // Two-deep history of issued operations
  logic        h1_v, h2_v;
  logic [11:0] h1_e, h2_e;
  string       h1_t, h2_t;
  logic [11:0] last_prod;

  gf4k_tower_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_mode(step_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference GF(64) multiply, modulo x^6+x+1
  function automatic logic [5:0] ref64(input logic [5:0] a, input logic [5:0] b);
    logic [6:0] bb;
    logic [5:0] c;
    c  = '0;
    bb = {1'b0, b};
    for (int i = 0; i < 6; i++) begin
      if (a[i]) c ^= bb[5:0];
      bb = bb << 1;
      if (bb[6]) bb ^= 7'h43;
    end
    return c;
  endfunction

  function automatic logic [11:0] ref4k(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hi, lo;
    hi = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ref64(a[5:0], b[5:0]);
    lo = ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ ref64(a[5:0], b[5:0]);
    return {hi, lo};
  endfunction

  function automatic logic [11:0] ref_step(input logic [11:0] a);
    return (a == '0) ? 12'h001 : ref4k(a, 12'hE01);
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: check the slot issued two cycles ago, then drive a new one
  task automatic cyc(input logic v, input logic stp, input logic [11:0] a,
                     input logic [11:0] b, input string tag);
    @(negedge clk);
    check("R8 valid", {11'd0, out_valid}, {11'd0, h2_v});
    if (h2_v) check(h2_t, product, h2_e);
    else      check("R9 hold", product, last_prod);
    last_prod = product;
    h2_v = h1_v; h2_e = h1_e; h2_t = h1_t;
    h1_v = v;
    h1_e = stp ? ref_step(a) : ref4k(a, b);
    h1_t = tag;
    in_valid = v; step_mode = stp; op_a = a; op_b = b;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] ra, rb, chain;
    void'($urandom(32'h5eed_0412));
    rst_n = 1'b0; in_valid = 1'b0; step_mode = 1'b0; op_a = '0; op_b = '0;
    h1_v = 1'b0; h2_v = 1'b0; h1_e = '0; h2_e = '0; h1_t = ""; h2_t = "";
    repeat (3) @(negedge clk);
    check("R10 out_valid", {11'd0, out_valid}, 12'd0);
    check("R10 product", product, 12'd0);
    last_prod = '0;
    rst_n = 1'b1;

    // Directed corners
    cyc(1, 0, 12'h000, 12'h5A3, "R3 a zero");
    cyc(1, 0, 12'hABC, 12'h000, "R3 b zero");
    cyc(1, 0, 12'h001, 12'h7E5, "R4 unit");
    cyc(1, 0, 12'hFFF, 12'h001, "R4 unit swapped");
    cyc(1, 1, 12'h000, 12'h123, "R6 step zero");
    cyc(1, 1, 12'h001, 12'h456, "R7 step of one");
    cyc(1, 0, 12'h040, 12'h040, "R2 high halves");
    cyc(1, 0, 12'h03F, 12'h03F, "R1 low halves");
    cyc(0, 0, 12'h999, 12'h999, "idle");
    cyc(0, 1, 12'h000, 12'h000, "idle");
    cyc(1, 0, 12'hFFF, 12'hFFF, "R1 all ones");

    // Random products with commutative swap
    for (int i = 0; i < 200; i++) begin
      ra = 12'($urandom);
      rb = 12'($urandom);
      cyc(1, 0, ra, rb, "R1 R2 random");
      cyc(1, 0, rb, ra, "R5 swapped");
      if (($urandom % 4) == 0) cyc(0, 0, 12'($urandom), 12'($urandom), "idle");
    end

    // Power chain: feed each step result back in
    chain = 12'h001;
    for (int i = 0; i < 50; i++) begin
      cyc(1, 1, chain, 12'($urandom), "R7 step chain");
      chain = ref_step(chain);
    end
    cyc(1, 1, 12'h000, 12'hFFF, "R6 step zero again");

    cyc(0, 0, 12'h000, 12'h000, "idle");
    cyc(0, 0, 12'h000, 12'h000, "idle");
    cyc(0, 0, 12'h000, 12'h000, "idle");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule